// File: doc/BRIEF.md
# Conversion Result Holding Register with Read Lock

This block keeps the latest result of an analog-to-digital conversion engine and presents it to a byte-wide register bus as two readable bytes. The result is right-adjusted: the low byte holds the bottom eight result bits and the high byte holds the remaining upper bits, padded with zeros. A processor reads the pair with two separate bus reads, low byte first. The block keeps the pair coherent, so the high byte always comes from the same conversion as the low byte that went before it.

Reading the low byte arms a lock. While the lock is armed, no new result may reach either byte. A conversion that completes in that window is thrown away. Reading the high byte releases the lock. The completion flag does not depend on the lock: it rises on every finished conversion, including one whose data was dropped. Software clears the flag by writing a one to it.

Top module: `adc_result_latch`

## Requirements
- R1: A synchronous active-high reset clears both bytes, the lock and the completion flag. After reset, the first conversion result is accepted.
- R2: When no lock is armed and `rd_lo` is low, a `res_valid` pulse loads both bytes at the clock edge that ends the pulse's cycle. The new data is readable in the next cycle.
- R3: The low byte equals result bits 7:0. The high byte equals result bits 9:8 in its bits 1:0, with bits 7:2 at zero. `rd_data` shows the low byte while `rd_lo` is high, the high byte while `rd_hi` is high, and zero when neither strobe is high.
- R4: A cycle with `rd_lo` high and `rd_hi` low arms the lock. A result that arrives in that cycle, or while the lock is armed, changes neither byte and is lost.
- R5: A cycle with `rd_hi` high releases the lock. The next result after that loads both bytes again.
- R6: `done_flag` is set at the edge after every `res_valid` pulse, whether or not the result was stored.
- R7: A `flag_clr` pulse clears `done_flag` at the next edge. If `res_valid` arrives in the same cycle, the flag is set instead.
- R8: Reading the high byte while no lock is armed leaves the block unlocked, so the next result is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle pulse: a conversion finished |
| res_data | input | 10 | Conversion result, valid with `res_valid` |
| rd_lo | input | 1 | Bus read strobe for the low result byte |
| rd_hi | input | 1 | Bus read strobe for the high result byte |
| flag_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| rd_data | output | 8 | Read data for the strobed byte, zero when idle |
| done_flag | output | 1 | Completion interrupt flag |

## Verification
The bench loads every 10-bit result value and reads both bytes back, computing each half arithmetically. A wrong split or a missing zero extension in the high byte shows up at the boundary values. Results that arrive while the lock is armed, and in the same cycle as the low-byte read, must leave the earlier pair intact. A block that locks only one edge late, or not at all, would return a high byte from a newer conversion. The bench confirms that a lone high-byte read does not lock, which a lock that toggles on either strobe would get wrong. It also checks that a dropped conversion still sets the flag, and that a completion wins over a clear arriving in the same cycle.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int BYTE_W = 8;

  // Zero-extended byte number idx of a right-adjusted result word.
  function automatic logic [BYTE_W-1:0] byte_of(input logic [15:0] word, input int idx);
    logic [BYTE_W-1:0] b;
    for (int i = 0; i < BYTE_W; i++) begin
      b[i] = word[idx*BYTE_W + i];
    end
    return b;
  endfunction
endpackage

// File: rtl/rl_lock_ctrl.sv
module rl_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic rd_lo,
  input  logic rd_hi,
  input  logic res_valid,
  output logic lock_q,
  output logic upd_accept,
  output logic upd_drop
);
  logic blocked;

  // The low-byte read cycle already counts as locked, so that the byte
  // returned on the bus and the byte still to come stay a matched pair.
  assign blocked    = lock_q | rd_lo;
  assign upd_accept = res_valid & ~blocked;
  assign upd_drop   = res_valid & blocked;

  always_ff @(posedge clk) begin
    if (rst)        lock_q <= 1'b0;
    else if (rd_hi) lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
  end
endmodule

// File: rtl/rl_byte_store.sv
module rl_byte_store #(
  parameter int RES_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [RES_W-1:0]            data,
  output logic [rl_pkg::BYTE_W-1:0]   lo_q,
  output logic [rl_pkg::BYTE_W-1:0]   hi_q
);
  localparam int NB = 2;
  logic [15:0] word;
  logic [rl_pkg::BYTE_W-1:0] bytes_q [NB];

  assign word = 16'(data);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)       bytes_q[g] <= '0;
      else if (load) bytes_q[g] <= rl_pkg::byte_of(word, g);
    end
  end

  assign lo_q = bytes_q[0];
  assign hi_q = bytes_q[1];
endmodule

// File: rtl/rl_done_flag.sv
module rl_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end
endmodule

// File: rtl/rl_read_mux.sv
module rl_read_mux (
  input  logic                      rd_lo,
  input  logic                      rd_hi,
  input  logic [rl_pkg::BYTE_W-1:0] lo_q,
  input  logic [rl_pkg::BYTE_W-1:0] hi_q,
  output logic [rl_pkg::BYTE_W-1:0] rd_data
);
  always_comb begin
    if (rd_lo)      rd_data = lo_q;
    else if (rd_hi) rd_data = hi_q;
    else            rd_data = '0;
  end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             flag_clr,
  output logic [7:0]       rd_data,
  output logic             done_flag
);
  logic       lock_q;
  logic       upd_accept;
  logic       upd_drop;
  logic [7:0] lo_q;
  logic [7:0] hi_q;

  rl_lock_ctrl u_lock (
    .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi), .res_valid(res_valid),
    .lock_q(lock_q), .upd_accept(upd_accept), .upd_drop(upd_drop)
  );

  rl_byte_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst), .load(upd_accept), .data(res_data),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  rl_done_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(res_valid), .clr_evt(flag_clr), .flag_q(done_flag)
  );

  rl_read_mux u_mux (
    .rd_lo(rd_lo), .rd_hi(rd_hi), .lo_q(lo_q), .hi_q(hi_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_result_latch_chk.sv
module adc_result_latch_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             rd_lo,
  input logic             rd_hi,
  input logic             flag_clr,
  input logic             done_flag,
  input logic             lock_q,
  input logic             upd_accept,
  input logic             upd_drop,
  input logic [7:0]       lo_q,
  input logic [7:0]       hi_q
);
  p_store_r2: assert property (@(posedge clk) disable iff (rst)
    upd_accept |=> (lo_q == $past(res_data[7:0])) && (hi_q[1:0] == $past(res_data[9:8])));

  p_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    hi_q[7:2] == 6'd0);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_q || rd_lo) |=> ($stable(lo_q) && $stable(hi_q)));

  p_lock_set_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock_q);

  p_unlock_r5: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock_q);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_accept || upd_drop) |=> done_flag);

  p_flag_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !res_valid) |=> !done_flag);

  p_no_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && !rd_lo) |=> !lock_q);
endmodule

bind adc_result_latch adc_result_latch_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr), .done_flag(done_flag),
  .lock_q(lock_q), .upd_accept(upd_accept), .upd_drop(upd_drop),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/adc_result_latch_bench.sv
module adc_result_latch_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rd_data;
  logic       done_flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_latch u_adc_result_latch (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
    .rd_data(rd_data), .done_flag(done_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bus cycle, started and ended at a falling edge; rd_data is sampled mid-cycle.
  task automatic cyc(input logic v, input logic [9:0] d, input logic lo,
                     input logic hi, input logic clr, output logic [7:0] rdat);
    res_valid = v; res_data = d; rd_lo = lo; rd_hi = hi; flag_clr = clr;
    #1 rdat = rd_data;
    @(negedge clk);
    res_valid = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic int exp_lo(input int v); return v % 256; endfunction
  function automatic int exp_hi(input int v); return v / 256; endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 flag", done_flag, 0);
    cyc(0, 0, 0, 0, 0, got); chk("R3 idle zero", got, 0);
    cyc(0, 0, 1, 0, 0, got); chk("R1 lo", got, 0);
    cyc(0, 0, 0, 1, 0, got); chk("R1 hi", got, 0);
    cyc(1, 10'd777, 0, 0, 0, got);
    cyc(0, 0, 1, 0, 0, got); chk("R1 first accepted", got, exp_lo(777));
    cyc(0, 0, 0, 1, 0, got); chk("R1 first accepted hi", got, exp_hi(777));

    // R2/R3: every result value
    for (int v = 0; v < 1024; v++) begin
      cyc(1, 10'(v), 0, 0, 0, got);
      cyc(0, 0, 1, 0, 0, got); chk("R3 lo sweep", got, exp_lo(v));
      cyc(0, 0, 0, 1, 0, got); chk("R2 hi sweep", got, exp_hi(v));
    end
    cyc(0, 0, 0, 0, 0, got); chk("R3 idle after read", got, 0);

    // R4: results while locked are dropped
    cyc(0, 0, 0, 0, 1, got); chk("R7 clear", done_flag, 0);
    cyc(1, 10'h2A5, 0, 0, 0, got);
    cyc(0, 0, 1, 0, 1, got); chk("R4 lo", got, 8'hA5);
    chk("R7 clear w/o valid", done_flag, 0);
    cyc(1, 10'h15A, 0, 0, 0, got);
    chk("R6 dropped sets flag", done_flag, 1);
    cyc(0, 0, 0, 1, 0, got); chk("R4 hi kept", got, 2);

    // R4: result in the same cycle as the low read is dropped
    cyc(1, 10'h0FF, 0, 0, 0, got);
    cyc(1, 10'h300, 1, 0, 0, got); chk("R4 lo same cycle", got, 8'hFF);
    cyc(0, 0, 0, 1, 0, got); chk("R4 hi same cycle", got, 0);

    // R5: after unlock the next result is stored
    cyc(1, 10'h1C3, 0, 0, 0, got);
    cyc(0, 0, 1, 0, 0, got); chk("R5 lo", got, 8'hC3);
    cyc(0, 0, 0, 1, 0, got); chk("R5 hi", got, 1);

    // R8: lone high read does not lock
    cyc(1, 10'h211, 0, 0, 0, got);
    cyc(0, 0, 0, 1, 0, got); chk("R8 hi alone", got, 2);
    cyc(1, 10'h122, 0, 0, 0, got);
    cyc(0, 0, 1, 0, 0, got); chk("R8 lo after", got, 8'h22);
    cyc(0, 0, 0, 1, 0, got); chk("R8 hi after", got, 1);

    // R7: completion wins over clear in the same cycle
    cyc(0, 0, 0, 0, 1, got); chk("R7 clear", done_flag, 0);
    cyc(1, 10'h3FF, 0, 0, 1, got); chk("R7 set priority", done_flag, 1);
    cyc(0, 0, 0, 0, 0, got); chk("R6 flag held", done_flag, 1);
    cyc(0, 0, 0, 0, 1, got); chk("R7 clear again", done_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule